// File: doc/BRIEF.md
# Per-Channel Conversion Controller

This block sequences a single oversampling converter channel from the moment a conversion is requested until a settled result is held for software. A trigger comes from one of two sources, picked by a configuration bit: a one-cycle software strobe, or an asynchronous hardware line. The hardware line is first brought into the modulator clock domain. An accepted trigger powers the analog path and the decimating filter. The controller then waits a programmable number of clock cycles of start-up and raises a ready flag. After that it counts filter outputs until the filter has settled.

The first two filter outputs after any start or restart are discarded, and the third is the first valid result. Each valid result goes into a result register and sets a completion flag. Depending on configuration it also raises a level interrupt or a one-cycle DMA request. In single mode the analog path shuts off after one result. In continuous mode every later filter output is kept. A new trigger during conversion restarts the sequence. Dropping either the channel enable or the master enable aborts at once, and the stored result is left untouched. An unread result that is replaced raises an overflow flag.

Top module: `conv_channel_ctrl`

## Requirements
- R1: Conversion runs only while both `chan_en` and `master_en` are high. Clearing either one forces `flt_en` and `ready` low on the next edge and keeps `result` unchanged. Triggers and filter outputs are ignored while the channel is inactive.
- R2: With `hw_trig_sel`=1 only the hardware line can start a conversion and `sw_trig` has no effect. With `hw_trig_sel`=0 only `sw_trig` can start one.
- R3: The hardware trigger passes through a two-stage synchroniser and a rising-edge detector. `flt_en` rises on the third clock edge after the line goes high. A line held high gives exactly one trigger.
- R4: Software trigger timing: `flt_en` goes high on the clock edge that samples the accepted trigger. `ready` rises max(`startup_cnt`,1) edges after that.
- R5: Triggers that arrive during start-up are ignored and do not move the time at which `ready` rises.
- R6: After every start or restart, the first two `flt_valid` pulses in the converting state are discarded. The third is stored.
- R7: A trigger while converting restarts the channel. `ready` drops, `flt_resync` pulses for one cycle, start-up runs again and the settling count begins again.
- R8: In single mode (`cont_mode`=0), `flt_en` and `ready` drop on the edge that stores the result. Later filter outputs are ignored until a new trigger.
- R9: In continuous mode (`cont_mode`=1), every `flt_valid` after settling is stored.
- R10: A stored result sets `coc`. `irq` equals `coc` when `irq_en`=1 and `dma_en`=0, and is low otherwise. `rd_strobe` clears `coc` and with it `irq`.
- R11: A result stored while `coc` is set, with no read in that cycle, sets `ovf`. `ovf` stays set until `ovf_clr` or `rd_strobe`.
- R12: With `dma_en`=1, each stored result gives a one-cycle `dma_req` on the same edge that updates `result`. `irq` stays low in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| master_en | input | 1 | Global enable shared by all channels |
| hw_trig_sel | input | 1 | 1 selects the hardware trigger, 0 the software strobe |
| sw_trig | input | 1 | Software trigger strobe |
| hw_trig_async | input | 1 | Asynchronous hardware trigger line |
| cont_mode | input | 1 | 1 selects continuous conversion |
| startup_cnt | input | CNT_W | Start-up length in clock cycles |
| irq_en | input | 1 | Interrupt request enable |
| dma_en | input | 1 | DMA request enable; takes precedence over the interrupt |
| rd_strobe | input | 1 | Result read strobe |
| ovf_clr | input | 1 | Overflow clear strobe |
| flt_valid | input | 1 | Filter output valid |
| flt_sample | input | DATA_W | Filter output sample, signed |
| flt_en | output | 1 | Enables the modulator, gain stage and filter |
| flt_resync | output | 1 | One-cycle filter resynchronise pulse on every start |
| ready | output | 1 | Start-up done, conversion in progress |
| result | output | DATA_W | Last stored result |
| coc | output | 1 | Conversion complete flag |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Interrupt request level |
| dma_req | output | 1 | DMA request pulse |

## Verification
The assertions check several things on every cycle. The path must be off after any loss of enable, the result register must hold whenever no filter output arrives, and a trigger during start-up must never cause a resync or early ready. They also check that overflow follows an unread replacement, that a read clears the completion flag, that single mode stops after each result, and that a DMA pulse always comes with a set completion flag. Other behaviour can only be shown by the bench scenarios, which compare exact counts of edges against the requirements. These cover the synchroniser latency and the single trigger from a held line, the exact edge on which start-up ends, the discarding of two outputs after each restart, and the choice between interrupt and DMA.

// File: rtl/conv_ctrl_pkg.sv
package conv_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_CONV  = 2'd2
  } conv_state_e;

  // Start-up ends in the cycle the counter has reached one or zero.
  function automatic logic startup_expired(input logic [31:0] cnt);
    return cnt <= 32'd1;
  endfunction

  // Filter has produced enough discarded outputs to trust the next one.
  function automatic logic filter_settled(input int seen, input int settle);
    return seen >= settle - 1;
  endfunction

  // Overflow: kept unless cleared or read, set on an unread replacement.
  function automatic logic overflow_next(input logic ovf, input logic coc,
                                         input logic accept, input logic rd,
                                         input logic clr);
    return (ovf & ~(rd | clr)) | (accept & coc & ~rd);
  endfunction

endpackage

// File: rtl/conv_trig_sync.sv
module conv_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/conv_startup_timer.sv
module conv_startup_timer
  import conv_ctrl_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (run && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = run & startup_expired(32'(cnt));
endmodule

// File: rtl/conv_result_store.sv
module conv_result_store
  import conv_ctrl_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] sample,
  input  logic              rd,
  input  logic              clr,
  input  logic              irq_en,
  input  logic              dma_en,
  output logic [DATA_W-1:0] result,
  output logic              coc,
  output logic              ovf,
  output logic              irq,
  output logic              dma_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      coc     <= 1'b0;
      ovf     <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      if (accept) result <= sample;
      coc     <= accept | (coc & ~rd);
      ovf     <= overflow_next(ovf, coc, accept, rd, clr);
      dma_req <= accept & dma_en;
    end
  end

  assign irq = coc & irq_en & ~dma_en;
endmodule

// File: rtl/conv_channel_ctrl.sv
module conv_channel_ctrl
  import conv_ctrl_pkg::*;
#(
  parameter int DATA_W    = 24,
  parameter int CNT_W     = 8,
  parameter int SETTLE    = 3,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              master_en,
  input  logic              hw_trig_sel,
  input  logic              sw_trig,
  input  logic              hw_trig_async,
  input  logic              cont_mode,
  input  logic [CNT_W-1:0]  startup_cnt,
  input  logic              irq_en,
  input  logic              dma_en,
  input  logic              rd_strobe,
  input  logic              ovf_clr,
  input  logic              flt_valid,
  input  logic [DATA_W-1:0] flt_sample,
  output logic              flt_en,
  output logic              flt_resync,
  output logic              ready,
  output logic [DATA_W-1:0] result,
  output logic              coc,
  output logic              ovf,
  output logic              irq,
  output logic              dma_req
);
  localparam int SET_W = $clog2(SETTLE) + 1;

  conv_state_e      state, state_nxt;
  logic [SET_W-1:0] seen_cnt;

  // Named internal events, observed by the checker.
  logic active, hw_rise, trig_evt, start_evt, in_startup, startup_done;
  logic settled, accept;

  conv_trig_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hw_trig_async), .rise(hw_rise)
  );

  assign active     = chan_en & master_en;
  assign trig_evt   = active & (hw_trig_sel ? hw_rise : sw_trig);
  assign in_startup = (state == ST_START);
  assign start_evt  = trig_evt & ~in_startup;

  conv_startup_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_val(startup_cnt),
    .run(in_startup), .done(startup_done)
  );

  assign settled = filter_settled(int'(seen_cnt), SETTLE);
  assign accept  = active & (state == ST_CONV) & flt_valid & settled & ~start_evt;

  always_comb begin
    state_nxt = state;
    if (!active)        state_nxt = ST_IDLE;
    else if (start_evt) state_nxt = ST_START;
    else begin
      case (state)
        ST_START: if (startup_done) state_nxt = ST_CONV;
        ST_CONV:  if (accept && !cont_mode) state_nxt = ST_IDLE;
        default:  state_nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      seen_cnt   <= '0;
      flt_resync <= 1'b0;
    end else begin
      state      <= state_nxt;
      flt_resync <= start_evt;
      if (start_evt)
        seen_cnt <= '0;
      else if (active && state == ST_CONV && flt_valid && !settled)
        seen_cnt <= seen_cnt + 1'b1;
    end
  end

  assign flt_en = (state != ST_IDLE);
  assign ready  = (state == ST_CONV);

  conv_result_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .accept(accept), .sample(flt_sample),
    .rd(rd_strobe), .clr(ovf_clr), .irq_en(irq_en), .dma_en(dma_en),
    .result(result), .coc(coc), .ovf(ovf), .irq(irq), .dma_req(dma_req)
  );
endmodule

// File: rtl/conv_channel_ctrl_checker.sv
module conv_channel_ctrl_checker #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chan_en,
  input logic              master_en,
  input logic              cont_mode,
  input logic              flt_valid,
  input logic              rd_strobe,
  input logic              accept,
  input logic              trig_evt,
  input logic              in_startup,
  input logic              startup_done,
  input logic              flt_en,
  input logic              flt_resync,
  input logic              ready,
  input logic [DATA_W-1:0] result,
  input logic              coc,
  input logic              ovf,
  input logic              dma_req
);
  p_abort_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(chan_en && master_en) |=> (!flt_en && !ready));

  p_result_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_valid |=> $stable(result));

  p_startup_no_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && in_startup && !startup_done) |=> (!flt_resync && !ready && flt_en));

  p_resync_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flt_resync |-> (flt_en && !ready));

  p_single_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cont_mode) |=> !flt_en);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !accept) |=> !coc);

  p_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && coc && !rd_strobe) |=> ovf);

  p_dma_with_result_r12: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> coc);
endmodule

bind conv_channel_ctrl conv_channel_ctrl_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .master_en(master_en),
  .cont_mode(cont_mode), .flt_valid(flt_valid), .rd_strobe(rd_strobe),
  .accept(accept), .trig_evt(trig_evt), .in_startup(in_startup),
  .startup_done(startup_done), .flt_en(flt_en), .flt_resync(flt_resync),
  .ready(ready), .result(result), .coc(coc), .ovf(ovf), .dma_req(dma_req)
);

// File: tb/conv_channel_ctrl_bench.sv
`timescale 1ns/1ps
module conv_channel_ctrl_bench;
  localparam int DW = 24;
  localparam int CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_en = 0, master_en = 0, hw_trig_sel = 0, sw_trig = 0, hw_trig_async = 0;
  logic cont_mode = 0, irq_en = 0, dma_en = 0, rd_strobe = 0, ovf_clr = 0, flt_valid = 0;
  logic [CW-1:0] startup_cnt = '0;
  logic [DW-1:0] flt_sample = '0;
  logic flt_en, flt_resync, ready, coc, ovf, irq, dma_req;
  logic [DW-1:0] result;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] prev_res = '0;

  always #2.5 clk = ~clk;

  conv_channel_ctrl u_conv_channel_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .master_en(master_en),
    .hw_trig_sel(hw_trig_sel), .sw_trig(sw_trig), .hw_trig_async(hw_trig_async),
    .cont_mode(cont_mode), .startup_cnt(startup_cnt), .irq_en(irq_en),
    .dma_en(dma_en), .rd_strobe(rd_strobe), .ovf_clr(ovf_clr),
    .flt_valid(flt_valid), .flt_sample(flt_sample), .flt_en(flt_en),
    .flt_resync(flt_resync), .ready(ready), .result(result), .coc(coc),
    .ovf(ovf), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: one filter output; pushes the expected result when it must be kept.
  task automatic give_sample(input logic [DW-1:0] v, input bit keep);
    @(negedge clk);
    flt_valid = 1; flt_sample = v;
    if (keep) exp_q.push_back(v);
    @(negedge clk);
    flt_valid = 0;
  endtask

  task automatic sw_pulse();
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
  endtask

  // Monitor: every change of the result register must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && result !== prev_res) begin
      if (exp_q.size() == 0) chk("R6 R9 unexpected result", longint'(result), longint'(prev_res));
      else chk("R6 R9 scoreboard", longint'(result), longint'(exp_q.pop_front()));
      prev_res = result;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // Reset state
    chk("R1 reset flt_en", flt_en, 0);
    chk("R4 reset ready", ready, 0);
    chk("R10 reset coc", coc, 0);
    chk("R11 reset ovf", ovf, 0);
    chk("R12 reset dma_req", dma_req, 0);

    // R4 / R5: software trigger, start-up of 4, retrigger in start-up ignored
    chan_en = 1; master_en = 1; irq_en = 1; startup_cnt = 8'd4;
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;            // after sampling edge E0
    chk("R4 flt_en after trigger", flt_en, 1);
    chk("R4 ready low in start-up", ready, 0);
    sw_trig = 1;                            // sampled at E1: must be ignored
    @(negedge clk); sw_trig = 0;
    chk("R5 no resync in start-up", flt_resync, 0);
    tick(2);                                // after E3
    chk("R5 ready still low", ready, 0);
    tick(1);                                // after E4
    chk("R4 R5 ready at start-up end", ready, 1);

    // R6 / R8 / R10: settle then single result
    give_sample(24'h111111, 0);
    give_sample(24'h222222, 0);
    chk("R6 discarded outputs", result, 0);
    give_sample(24'h3A5C01, 1);
    chk("R6 third stored", result, 24'h3A5C01);
    chk("R10 coc set", coc, 1);
    chk("R10 irq level", irq, 1);
    chk("R8 flt_en off after single", flt_en, 0);
    chk("R8 ready off after single", ready, 0);
    give_sample(24'h0BAD01, 0);
    chk("R8 later output ignored", result, 24'h3A5C01);
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    chk("R10 read clears coc", coc, 0);
    chk("R10 read clears irq", irq, 0);

    // R2 / R3: hardware trigger select, continuous mode
    hw_trig_sel = 1; cont_mode = 1; startup_cnt = 8'd2;
    sw_pulse();
    tick(1);
    chk("R2 sw ignored in hw mode", flt_en, 0);
    @(negedge clk); hw_trig_async = 1;      // N0
    tick(2);
    chk("R3 not yet through sync", flt_en, 0);
    tick(1);
    chk("R3 flt_en three edges later", flt_en, 1);
    chk("R7 resync on start", flt_resync, 1);
    tick(2);
    chk("R3 R4 ready after start-up", ready, 1);
    tick(3);
    chk("R3 held line no retrigger", flt_resync, 0);
    chk("R3 held line still ready", ready, 1);

    give_sample(24'h000011, 0);
    give_sample(24'h000022, 0);
    give_sample(24'h7FFFF0, 1);
    chk("R10 coc continuous", coc, 1);
    give_sample(24'h800005, 1);
    chk("R9 continuous second result", result, 24'h800005);
    chk("R11 overflow on unread", ovf, 1);
    chk("R9 still converting", ready, 1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R11 clear strobe", ovf, 0);
    chk("R11 clear keeps coc", coc, 1);
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0;
    chk("R10 read clears", coc, 0);

    // R12: DMA pulse, interrupt suppressed
    dma_en = 1;
    @(negedge clk);
    flt_valid = 1; flt_sample = 24'h0D0A01; exp_q.push_back(24'h0D0A01);
    @(negedge clk); flt_valid = 0;
    chk("R12 dma pulse", dma_req, 1);
    chk("R12 irq suppressed", irq, 0);
    @(negedge clk);
    chk("R12 dma one cycle", dma_req, 0);
    @(negedge clk); rd_strobe = 1;
    @(negedge clk); rd_strobe = 0; dma_en = 0;

    // R7: restart during conversion via new hardware edge
    hw_trig_async = 0;
    tick(3);
    @(negedge clk); hw_trig_async = 1;
    tick(2);
    chk("R7 ready before restart", ready, 1);
    tick(1);
    chk("R7 resync pulse", flt_resync, 1);
    chk("R7 ready drops", ready, 0);
    tick(1);
    chk("R7 resync one cycle", flt_resync, 0);
    tick(1);
    chk("R7 ready again", ready, 1);
    give_sample(24'h0C0001, 0);
    give_sample(24'h0C0002, 0);
    chk("R7 outputs discarded after restart", result, 24'h0D0A01);
    give_sample(24'h0C0003, 1);
    chk("R7 third after restart", result, 24'h0C0003);

    // R1: abort with master enable
    @(negedge clk); master_en = 0;
    @(negedge clk);
    chk("R1 abort flt_en", flt_en, 0);
    chk("R1 abort ready", ready, 0);
    give_sample(24'h0EEEEE, 0);
    chk("R1 result kept", result, 24'h0C0003);
    @(negedge clk); master_en = 1;
    tick(2);
    chk("R1 re-enable needs trigger", flt_en, 0);

    // R1 / R2: channel disabled ignores software trigger
    hw_trig_sel = 0; hw_trig_async = 0; chan_en = 0; cont_mode = 0; startup_cnt = 8'd0;
    sw_pulse();
    tick(1);
    chk("R1 trigger ignored when disabled", flt_en, 0);
    chan_en = 1;
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
    chk("R2 sw trigger in sw mode", flt_en, 1);
    @(negedge clk);
    chk("R4 zero start-up one cycle", ready, 1);

    tick(2);
    chk("R9 all expected results seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule